// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a behavioural controller for a NOR-style flash array. Every bus write cycle is decoded as a command byte or as the data or confirm cycle of a two-cycle operation. It runs a program sequencer and a block-erase sequencer. Each sequencer counts clock cycles in place of real array timing. A small register array stands in for the memory cells.

An erase in progress can be suspended and resumed. While the erase is suspended, a program may run in another block, and reads of the suspended block are flagged. A running program can also be suspended so that another block can be read. A status register reports the following:

- readiness
- both suspend states
- failure causes

The boot block (block 0) is writable only while the write-protect input is held high. A low-supply input blocks all write cycles. The active-low reset aborts all work and returns the block to array-read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A program needs a 40h setup cycle followed by a data cycle that stores the data byte at that address. A lone write cycle with no setup changes neither the array nor busy.
- R2: A 20h setup followed by a D0h confirm sets every word of the addressed block to all ones. A setup followed by any other byte starts nothing and sets status bits 5 and 4 (sequence error).
- R3: After the cycle that starts it, busy stays high for PROG_CYC clock cycles for a program and for ERASE_CYC clock cycles for an erase. Status bit 7 reads 1 exactly when busy is low.
- R4: B0h during a running erase sets status bit 6 and freezes the remaining erase count. D0h clears bit 6, and the erase then finishes after only the cycles that remained.
- R5: While an erase or a program is suspended, a read in array mode of the suspended operation's block raises rd_bad. Reads of other blocks return array data with rd_bad low.
- R6: While an erase is suspended, a program to a different block runs and completes while status bit 6 stays set. A program into the suspended block is refused, which sets status bit 4.
- R7: B0h during a running program sets status bit 2 and pauses it. D0h resumes it, and the program completes with its remaining cycles.
- R8: While rst_n is low, both sequencers are aborted, status bits 6 to 0 are cleared and busy is low. After reset the block is in array-read mode.
- R9: With wp_en low, a program or erase aimed at block 0 is refused. A refused program sets status bits 1 and 4, and a refused erase sets bits 1 and 5, and the array is unchanged. With wp_en high the same operations run. Block 0 is locked again as soon as wp_en returns low.
- R10: While vlow is high, every write cycle is ignored. This covers commands, setup cycles and data cycles.
- R11: 70h selects status reads, so rdata shows the status byte. FFh selects array reads. 50h clears status bits 5, 4 and 1. Setup and suspend commands also switch rdata to status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; aborts all operations |
| addr | input | ADDR_W | Word address; the top BLK_BITS bits select the block |
| wdata | input | DATA_W | Write data; the low byte is the command code |
| we | input | 1 | One-cycle write strobe |
| wp_en | input | 1 | High unlocks the boot block |
| vlow | input | 1 | Low-supply lockout; high blocks all writes |
| rdata | output | DATA_W | Array word or status byte, depending on read mode |
| rd_bad | output | 1 | Current array read targets a suspended block |
| status | output | 8 | Status register |
| busy | output | 1 | A sequencer is counting |

## Verification
Some properties are checked on every cycle:

- the erase count is frozen while the erase is suspended
- a program starts only from an armed setup
- a program never runs in the block of an active erase
- rd_bad appears only with a suspend in force
- writes under low supply leave an idle block untouched
- reset clears the status flags

The following rest on the bench's directed scenarios:

- exact busy lengths, including the remaining count after a resume
- array contents after program and erase
- sequence-error and lock status codes
- boot-block re-locking
- the mode left behind after reset

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W    = 6,
  parameter int BLK_BITS  = 2,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 16,
  parameter int BOOT_BLK  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              wp_en,
  input  logic              vlow,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_bad,
  output logic [7:0]        status,
  output logic              busy
);
  localparam int WORDS     = 1 << ADDR_W;
  localparam int OFF_W     = ADDR_W - BLK_BITS;
  localparam int BLK_WORDS = 1 << OFF_W;
  localparam int CW        = $clog2(ERASE_CYC + 1);

  logic [DATA_W-1:0] mem [WORDS];

  logic [1:0]          pend;
  logic                rd_stat;
  logic                er_act, er_susp, pg_act, pg_susp;
  logic                f_er, f_pg, f_lock;
  logic [BLK_BITS-1:0] er_blk;
  logic [ADDR_W-1:0]   pg_addr;
  logic [DATA_W-1:0]   pg_data;
  logic [CW-1:0]       er_cnt, pg_cnt;
  logic [DATA_W-1:0]   stat_w;

  wire                wr        = we & ~vlow;
  wire [7:0]          cmd       = wdata[7:0];
  wire [BLK_BITS-1:0] a_blk     = addr[ADDR_W-1 -: BLK_BITS];
  wire [BLK_BITS-1:0] pg_blk    = pg_addr[ADDR_W-1 -: BLK_BITS];
  wire                boot_lock = (a_blk == BOOT_BLK[BLK_BITS-1:0]) & ~wp_en;
  wire                pg_run    = pg_act & ~pg_susp;
  wire                er_run    = er_act & ~er_susp;
  wire                pg_done   = pg_run & (pg_cnt == CW'(1));
  wire                er_done   = er_run & (er_cnt == CW'(1));
  wire                prog_armed = (pend == 2'd1);

  assign busy   = pg_run | er_run;
  assign status = {~busy, er_susp, f_er, f_pg, 1'b0, pg_susp, f_lock, 1'b0};
  assign rd_bad = ~rd_stat & ((er_susp & (a_blk == er_blk)) | (pg_susp & (a_blk == pg_blk)));

  always_comb begin
    stat_w      = '0;
    stat_w[7:0] = status;
  end
  assign rdata = rd_stat ? stat_w : mem[addr];

  always_ff @(posedge clk) begin
    if (pg_done) mem[pg_addr] <= pg_data;
    if (er_done)
      for (int j = 0; j < BLK_WORDS; j++)
        mem[{er_blk, OFF_W'(j)}] <= '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'd0; rd_stat <= 1'b0;
      er_act <= 1'b0; er_susp <= 1'b0; pg_act <= 1'b0; pg_susp <= 1'b0;
      f_er <= 1'b0; f_pg <= 1'b0; f_lock <= 1'b0;
      er_blk <= '0; pg_addr <= '0; pg_data <= '0; er_cnt <= '0; pg_cnt <= '0;
    end else begin
      if (pg_run) begin
        if (pg_done) pg_act <= 1'b0;
        else         pg_cnt <= pg_cnt - CW'(1);
      end
      if (er_run) begin
        if (er_done) er_act <= 1'b0;
        else         er_cnt <= er_cnt - CW'(1);
      end
      if (wr) begin
        pend <= 2'd0;
        case (pend)
          2'd1: begin
            rd_stat <= 1'b1;
            if (boot_lock) begin
              f_lock <= 1'b1; f_pg <= 1'b1;
            end else if (er_susp && a_blk == er_blk) begin
              f_pg <= 1'b1;
            end else begin
              pg_act <= 1'b1; pg_cnt <= CW'(PROG_CYC);
              pg_addr <= addr; pg_data <= wdata;
            end
          end
          2'd2: begin
            rd_stat <= 1'b1;
            if (cmd != 8'hD0) begin
              f_er <= 1'b1; f_pg <= 1'b1;
            end else if (boot_lock) begin
              f_lock <= 1'b1; f_er <= 1'b1;
            end else begin
              er_act <= 1'b1; er_cnt <= CW'(ERASE_CYC); er_blk <= a_blk;
            end
          end
          default: begin
            case (cmd)
              8'h40: if (!pg_act && (!er_act || er_susp)) begin pend <= 2'd1; rd_stat <= 1'b1; end
              8'h20: if (!pg_act && !er_act) begin pend <= 2'd2; rd_stat <= 1'b1; end
              8'hB0: begin
                rd_stat <= 1'b1;
                if (pg_run && !pg_done) pg_susp <= 1'b1;
                else if (er_run && !pg_act && !er_done) er_susp <= 1'b1;
              end
              8'hD0: begin
                if (pg_susp) pg_susp <= 1'b0;
                else if (er_susp && !pg_act) er_susp <= 1'b0;
              end
              8'h70: rd_stat <= 1'b1;
              8'h50: begin f_er <= 1'b0; f_pg <= 1'b0; f_lock <= 1'b0; end
              8'hFF: rd_stat <= 1'b0;
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

module flash_cmd_ctrl_chk #(
  parameter int CW = 5,
  parameter int BW = 2,
  parameter int PROG_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic          vlow,
  input logic          busy,
  input logic          rd_bad,
  input logic [7:0]    status,
  input logic          er_act,
  input logic          er_susp,
  input logic          pg_act,
  input logic          pg_susp,
  input logic          prog_armed,
  input logic [CW-1:0] er_cnt,
  input logic [CW-1:0] pg_cnt,
  input logic [BW-1:0] er_blk,
  input logic [BW-1:0] pg_blk
);
  a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (er_susp && $past(er_susp)) |-> $stable(er_cnt));

  a_r1_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_act) |-> $past(prog_armed));

  a_r6_other_block: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_act && er_act) |-> (er_susp && pg_blk != er_blk));

  a_r5_bad_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (er_susp || pg_susp));

  a_r10_lockout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow && we && !busy) |=> ($stable(status) && !busy));

  a_r8_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (status[6:0] == 7'd0 && !busy)));

  a_r3_prog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pg_act |-> (pg_cnt != '0 && pg_cnt <= CW'(PROG_CYC)));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.CW(CW), .BW(BLK_BITS), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .vlow(vlow), .busy(busy), .rd_bad(rd_bad),
  .status(status), .er_act(er_act), .er_susp(er_susp), .pg_act(pg_act),
  .pg_susp(pg_susp), .prog_armed(prog_armed), .er_cnt(er_cnt), .pg_cnt(pg_cnt),
  .er_blk(er_blk), .pg_blk(pg_blk)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int AW = 6, DW = 8, PC = 4, EC = 16;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, wp_en = 1'b0, vlow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_bad, busy;
  logic [7:0] status;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BLK_BITS(2), .DATA_W(DW), .PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .wp_en(wp_en),
    .vlow(vlow), .rdata(rdata), .rd_bad(rd_bad), .status(status), .busy(busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic bad);
    addr = a; #1;
    d = rdata; bad = rd_bad;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic program_word(input logic [AW-1:0] a, input logic [DW-1:0] d, output int n);
    wr('0, 8'h40); wr(a, d); wait_idle(n);
  endtask

  task automatic t_reset;
    check("R8 reset status", status, 8'h80);
    check("R8 reset busy", busy, 0);
    check("R8 reset rd_bad", rd_bad, 0);
  endtask

  task automatic t_program;
    logic [DW-1:0] d; logic b; int n;
    program_word(6'd18, 8'h12, n);
    check("R3 program length", n, PC);
    check("R11 status after program", rdata, 8'h80);
    wr('0, 8'hFF); rd(6'd18, d, b);
    check("R1 programmed data", d, 8'h12);
    wr(6'd18, 8'h3C);
    check("R1 stray write busy", busy, 0);
    rd(6'd18, d, b);
    check("R1 stray write data", d, 8'h12);
  endtask

  task automatic t_erase;
    logic [DW-1:0] d; logic b; int n;
    program_word(6'd34, 8'h55, n);
    wr('0, 8'h20); wr(6'd34, 8'hD0); wait_idle(n);
    check("R3 erase length", n, EC);
    wr('0, 8'hFF); rd(6'd34, d, b);
    check("R2 erased word", d, 8'hFF);
    rd(6'd18, d, b);
    check("R2 other block kept", d, 8'h12);
    wr('0, 8'h20); wr(6'd34, 8'h11);
    check("R2 sequence error", status, 8'hB0);
    check("R2 no erase started", busy, 0);
    wr('0, 8'h50);
    check("R11 clear status", status, 8'h80);
  endtask

  task automatic t_erase_suspend;
    logic [DW-1:0] d; logic b; int n;
    wr('0, 8'h20); wr(6'd32, 8'hD0);
    repeat (5) @(negedge clk);
    wr('0, 8'hB0);
    check("R4 suspended status", status, 8'hC0);
    repeat (3) @(negedge clk);
    check("R4 stays suspended", status, 8'hC0);
    wr('0, 8'hFF); rd(6'd32, d, b);
    check("R5 suspended block flagged", b, 1);
    rd(6'd18, d, b);
    check("R5 other block not flagged", b, 0);
    check("R5 other block data", d, 8'h12);
    wr('0, 8'h40); wr(6'd33, 8'h09);
    check("R6 same block refused", status, 8'hD0);
    wr('0, 8'h50);
    program_word(6'd50, 8'h77, n);
    check("R6 program during suspend", n, PC);
    check("R6 erase still suspended", status, 8'hC0);
    wr('0, 8'hD0); wait_idle(n);
    check("R4 remaining erase cycles", n, EC - 6);
    check("R4 ready after resume", status, 8'h80);
    wr('0, 8'hFF); rd(6'd32, d, b);
    check("R4 block erased", d, 8'hFF);
    rd(6'd50, d, b);
    check("R6 programmed word", d, 8'h77);
  endtask

  task automatic t_prog_suspend;
    logic [DW-1:0] d; logic b; int n;
    wr('0, 8'h40); wr(6'd20, 8'h44);
    wr('0, 8'hB0);
    check("R7 program suspended", status, 8'h84);
    wr('0, 8'hFF); rd(6'd34, d, b);
    check("R7 read other block", {b, d}, {1'b0, 8'hFF});
    rd(6'd21, d, b);
    check("R5 program block flagged", b, 1);
    wr('0, 8'hD0); wait_idle(n);
    check("R7 remaining program cycles", n, PC - 1);
    wr('0, 8'hFF); rd(6'd20, d, b);
    check("R7 programmed data", d, 8'h44);
  endtask

  task automatic t_boot;
    logic [DW-1:0] d; logic b; int n;
    wp_en = 1'b0;
    wr('0, 8'h40); wr(6'd3, 8'hAB);
    check("R9 locked program", status, 8'h92);
    wr('0, 8'h50);
    wr('0, 8'h20); wr(6'd3, 8'hD0);
    check("R9 locked erase", status, 8'hA2);
    check("R9 locked erase busy", busy, 0);
    wr('0, 8'h50);
    wp_en = 1'b1;
    program_word(6'd3, 8'hAB, n);
    check("R9 unlocked program", n, PC);
    wp_en = 1'b0;
    wr('0, 8'h40); wr(6'd3, 8'h01);
    check("R9 relocked", status, 8'h92);
    wr('0, 8'h50); wr('0, 8'hFF); rd(6'd3, d, b);
    check("R9 boot data", d, 8'hAB);
  endtask

  task automatic t_vlow;
    logic [DW-1:0] d; logic b;
    vlow = 1'b1;
    wr('0, 8'h40); wr(6'd18, 8'h00);
    check("R10 no program", busy, 0);
    check("R10 status unchanged", status, 8'h80);
    vlow = 1'b0;
    rd(6'd18, d, b);
    check("R10 data and mode kept", d, 8'h12);
    wr(6'd18, 8'h00);
    rd(6'd18, d, b);
    check("R10 setup not armed", d, 8'h12);
  endtask

  task automatic t_abort;
    logic [DW-1:0] d; logic b;
    wr('0, 8'h20); wr(6'd40, 8'hD0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 aborted busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 status after abort", status, 8'h80);
    rd(6'd18, d, b);
    check("R8 array mode after reset", d, 8'h12);
    wr('0, 8'h70); rd(6'd18, d, b);
    check("R11 read status mode", d, 8'h80);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_erase_suspend();
    t_prog_suspend();
    t_boot();
    t_vlow();
    t_abort();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule